// File: doc/BRIEF.md
# Vertical Sync Pulse Width Regenerator

This block sits after a vertical sync filter and decides the width of the vertical sync pulse that leaves it. With regeneration switched off, the incoming vertical sync is copied to the output one clock later, so the output pulse is exactly as wide as the input pulse. With regeneration switched on, each rising edge of the incoming vertical sync starts a fresh output pulse. That pulse then stays high for a programmed number of line periods, counted on the horizontal sync strobe, whatever the input does after its rising edge.

Horizontal and vertical sync arrive as active-high signals that are synchronous to the block clock. The horizontal sync input is a one-clock strobe per line. The enable bit and the 8-bit line count come in on plain input ports and are registered inside the block. A line count of zero is treated as one line, so a regenerated pulse is never lost. A rising edge that arrives while a pulse is already running starts the count again.

Top module: `vsyncRegen`

## Requirements
- R1: While reset is asserted `vsyncOut` is 0. The internal enable register resets to disabled and the internal line-count register resets to 10. On the first clock after reset is released the block therefore acts as a pass-through, whatever the ports carry.
- R2: The port settings are copied into the internal registers on every clock, so a change at `regenEn` or `durLines` takes effect one clock after it is sampled.
- R3: With regeneration disabled (`regenEn` = 0), `vsyncOut` equals `vsyncIn` delayed by one clock, so the output pulse is as wide as the input pulse.
- R4: With regeneration enabled (`regenEn` = 1), a 0-to-1 transition of `vsyncIn` makes `vsyncOut` go to 1 on the following clock.
- R5: With regeneration enabled, the output pulse stays at 1 until the N-th `hsyncStb` strobe after the leading edge, where N is the registered line count. The output goes to 0 one clock after that strobe is sampled. A strobe that is sampled in the same clock as the leading edge is not counted.
- R6: A line count of 0 behaves as a count of 1.
- R7: With regeneration enabled, the width of the input pulse has no effect on the output. A short input pulse still gives the full programmed width, and an input that stays high longer than the programmed width does not extend the output.
- R8: A new leading edge of `vsyncIn` during an active regenerated pulse restarts the line count from the current setting.
- R9: The line count is taken at the leading edge. A change of `durLines` during a pulse does not alter that pulse.
- R10: Disabling regeneration during a pulse drops the pulse and returns to pass-through. A later re-enable does not resume the dropped pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| hsyncStb | input | 1 | One-clock strobe per line, active high |
| vsyncIn | input | 1 | Filtered vertical sync, active high |
| regenEn | input | 1 | 1 = regenerate pulse width, 0 = pass through |
| durLines | input | 8 | Regenerated pulse width in lines (0 acts as 1) |
| vsyncOut | output | 1 | Vertical sync after width regeneration |

## Verification
The assertions assume that both sync inputs are already synchronous to `clk`. They also assume that a configuration change can land in any cycle, including in the middle of a pulse, so no property depends on settings staying fixed between edges. The stimulus changes every input just after the falling clock edge and never drives a horizontal strobe longer than one clock. It places leading edges in chosen relation to strobes: coincident with one, right after one, and inside a running pulse. This covers every ordering that the counting rule distinguishes.

// File: rtl/vregen_pkg.sv
package vregen_pkg;

  // Per-cycle commands from the control to the datapath
  typedef struct packed {
    logic bypass;   // pass input straight through
    logic load;     // start a new pulse with the sampled width
    logic dec;      // one line elapsed inside a pulse
  } regenCmd_t;

endpackage

// File: rtl/vregenCtl.sv
module vregenCtl
  import vregen_pkg::*;
#(
  parameter int DUR_W   = 8,
  parameter int DUR_RST = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hsyncStb,
  input  logic             vsyncIn,
  input  logic             regenEn,
  input  logic [DUR_W-1:0] durLines,
  output regenCmd_t        cmd,
  output logic [DUR_W-1:0] loadVal
);

  localparam logic [DUR_W-1:0] RST_DUR = DUR_W'(DUR_RST);
  localparam logic [DUR_W-1:0] ONE_DUR = DUR_W'(1);

  logic             cfgEn;
  logic [DUR_W-1:0] cfgDur;
  logic             vsPrev;
  logic             leadEdge;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgEn  <= 1'b0;
      cfgDur <= RST_DUR;
      vsPrev <= 1'b0;
    end else begin
      cfgEn  <= regenEn;
      cfgDur <= durLines;
      vsPrev <= vsyncIn;
    end
  end

  assign leadEdge = vsyncIn & ~vsPrev;

  always_comb begin
    cmd.bypass = ~cfgEn;
    cmd.load   = cfgEn & leadEdge;
    cmd.dec    = cfgEn & hsyncStb & ~leadEdge;
    loadVal    = (cfgDur == '0) ? ONE_DUR : cfgDur;
  end

  // R1
  reset_dflt_chk: assert property (@(posedge clk)
    !rstN |=> (cfgEn == 1'b0) && (cfgDur == RST_DUR));

  // R2
  cfg_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (cfgEn == $past(regenEn)) && (cfgDur == $past(durLines)));

endmodule

// File: rtl/vregenDp.sv
module vregenDp
  import vregen_pkg::*;
#(
  parameter int DUR_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             vsyncIn,
  input  regenCmd_t        cmd,
  input  logic [DUR_W-1:0] loadVal,
  output logic             vsyncOut
);

  localparam logic [DUR_W-1:0] ONE_DUR = DUR_W'(1);

  logic [DUR_W-1:0] lineCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineCnt  <= '0;
      vsyncOut <= 1'b0;
    end else if (cmd.bypass) begin
      lineCnt  <= '0;
      vsyncOut <= vsyncIn;
    end else if (cmd.load) begin
      lineCnt  <= loadVal;
      vsyncOut <= 1'b1;
    end else if (cmd.dec && lineCnt != '0) begin
      lineCnt  <= lineCnt - ONE_DUR;
      vsyncOut <= (lineCnt != ONE_DUR);
    end else begin
      vsyncOut <= (lineCnt != '0);
    end
  end

  // R3
  pass_thru_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.bypass |=> vsyncOut == $past(vsyncIn));

  // R4
  pulse_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.load |=> vsyncOut);

  // R6
  never_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.load |=> lineCnt != '0);

  // R5
  pulse_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.dec && !cmd.bypass && !cmd.load && lineCnt == ONE_DUR)
      |=> !vsyncOut && lineCnt == '0);

  // R7
  hold_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.bypass && !cmd.load && !cmd.dec)
      |=> $stable(lineCnt) && (vsyncOut == (lineCnt != '0)));

endmodule

// File: rtl/vsyncRegen.sv
module vsyncRegen
  import vregen_pkg::*;
#(
  parameter int DUR_W   = 8,
  parameter int DUR_RST = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hsyncStb,
  input  logic             vsyncIn,
  input  logic             regenEn,
  input  logic [DUR_W-1:0] durLines,
  output logic             vsyncOut
);

  regenCmd_t        cmd;
  logic [DUR_W-1:0] loadVal;

  vregenCtl #(.DUR_W(DUR_W), .DUR_RST(DUR_RST)) i_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .hsyncStb (hsyncStb),
    .vsyncIn  (vsyncIn),
    .regenEn  (regenEn),
    .durLines (durLines),
    .cmd      (cmd),
    .loadVal  (loadVal)
  );

  vregenDp #(.DUR_W(DUR_W)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .vsyncIn  (vsyncIn),
    .cmd      (cmd),
    .loadVal  (loadVal),
    .vsyncOut (vsyncOut)
  );

  // R1
  out_reset_chk: assert property (@(posedge clk)
    !rstN |=> !vsyncOut);

endmodule

// File: tb/test_vsyncRegen.sv
module test_vsyncRegen;

  logic       clk = 1'b0;
  logic       rstN;
  logic       hsyncStb;
  logic       vsyncIn;
  logic       regenEn;
  logic [7:0] durLines;
  logic       vsyncOut;

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;  // 50 MHz

  vsyncRegen i_vsyncRegen (
    .clk(clk), .rstN(rstN), .hsyncStb(hsyncStb), .vsyncIn(vsyncIn),
    .regenEn(regenEn), .durLines(durLines), .vsyncOut(vsyncOut)
  );

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check(input string req, input logic exp);
    nChecks++;
    if (vsyncOut !== exp) begin
      nFails++;
      $display("FAIL %s: vsyncOut=%b expected %b at %0t", req, vsyncOut, exp, $time);
    end
  endtask

  // Apply one hsync strobe, then check the output after that edge
  task automatic strobe(input string req, input logic exp);
    hsyncStb = 1'b1;
    step();
    hsyncStb = 1'b0;
    check(req, exp);
  endtask

  task automatic setup(input logic en, input logic [7:0] dur);
    vsyncIn  = 1'b0;
    hsyncStb = 1'b0;
    regenEn  = en;
    durLines = dur;
    step(4);
  endtask

  // R1: reset state and disabled default on the first clock after release
  task automatic tReset();
    rstN = 1'b0; vsyncIn = 1'b1; regenEn = 1'b1; durLines = 8'd3; hsyncStb = 1'b0;
    step(3);
    check("R1", 1'b0);
    rstN = 1'b1;
    step();
    check("R1", 1'b1);   // enable register still at reset value: pass-through
    step();
    check("R1", 1'b0);   // now enabled, level without edge gives no pulse
    vsyncIn = 1'b0;
    step(2);
  endtask

  // R3: pass-through keeps width and delays by one clock
  task automatic tBypass();
    setup(1'b0, 8'd2);
    vsyncIn = 1'b1;
    check("R3", 1'b0);
    step();
    check("R3", 1'b1);
    hsyncStb = 1'b1;
    step(); hsyncStb = 1'b0;
    step(3);
    check("R3", 1'b1);
    vsyncIn = 1'b0;
    step();
    check("R3", 1'b0);
  endtask

  // R4, R5, R7 (short input): width counted on strobes with gaps
  task automatic tWidth(input logic [7:0] dur, input int gap);
    setup(1'b1, dur);
    vsyncIn = 1'b1;
    step();
    check("R4", 1'b1);
    vsyncIn = 1'b0;      // input pulse only one clock wide
    for (int k = 1; k <= dur; k++) begin
      step(gap);
      check("R7", 1'b1);
      strobe("R5", k < dur);
    end
    step(2);
    check("R5", 1'b0);
  endtask

  // R5: strobe coincident with the leading edge is not counted
  task automatic tCoincide();
    setup(1'b1, 8'd2);
    vsyncIn = 1'b1;
    hsyncStb = 1'b1;
    step();
    hsyncStb = 1'b0;
    check("R5", 1'b1);
    strobe("R5", 1'b1);
    strobe("R5", 1'b0);
    vsyncIn = 1'b0;
  endtask

  // R7: long input does not stretch the output
  task automatic tLongInput();
    setup(1'b1, 8'd1);
    vsyncIn = 1'b1;
    step();
    check("R7", 1'b1);
    strobe("R7", 1'b0);
    step(5);
    check("R7", 1'b0);
    vsyncIn = 1'b0;
    step();
    check("R7", 1'b0);
  endtask

  // R6: zero line count acts as one
  task automatic tZero();
    setup(1'b1, 8'd0);
    vsyncIn = 1'b1;
    step();
    vsyncIn = 1'b0;
    check("R6", 1'b1);
    step(3);
    check("R6", 1'b1);
    strobe("R6", 1'b0);
  endtask

  // R8: a new leading edge restarts the count
  task automatic tRetrigger();
    setup(1'b1, 8'd3);
    vsyncIn = 1'b1;
    step();
    vsyncIn = 1'b0;
    strobe("R8", 1'b1);
    strobe("R8", 1'b1);
    vsyncIn = 1'b1;
    step();
    vsyncIn = 1'b0;
    check("R8", 1'b1);
    strobe("R8", 1'b1);
    strobe("R8", 1'b1);
    strobe("R8", 1'b0);
  endtask

  // R9 and R2: width fixed at the edge; setting change acts later
  task automatic tDurChange();
    setup(1'b1, 8'd2);
    vsyncIn = 1'b1;
    step();
    vsyncIn = 1'b0;
    durLines = 8'd6;
    step(2);
    strobe("R9", 1'b1);
    strobe("R9", 1'b0);
    // R2: the new setting of 6 applies to the next pulse
    vsyncIn = 1'b1;
    step();
    vsyncIn = 1'b0;
    for (int k = 1; k <= 6; k++) strobe("R2", k < 6);
  endtask

  // R10 and R2: disable mid-pulse, re-enable does not resume
  task automatic tDisable();
    setup(1'b1, 8'd5);
    vsyncIn = 1'b1;
    step();
    vsyncIn = 1'b0;
    strobe("R10", 1'b1);
    regenEn = 1'b0;
    step();
    check("R2", 1'b1);   // enable register not yet updated
    step();
    check("R10", 1'b0);
    regenEn = 1'b1;
    step(2);
    check("R10", 1'b0);
    strobe("R10", 1'b0);
    step(3);
    check("R10", 1'b0);
  endtask

  initial begin
    fork
      begin
        tReset();
        tBypass();
        tWidth(8'd3, 0);
        tWidth(8'd4, 3);
        tWidth(8'd10, 1);
        tCoincide();
        tLongInput();
        tZero();
        tRetrigger();
        tDurChange();
        tDisable();
      end
      begin
        repeat (20000) @(posedge clk);
        nChecks++;
        nFails++;
        $display("FAIL watchdog: run did not finish, actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule